// File: doc/BRIEF.md
# Extended Burst-Mode Handshake Controller

This block is a clocked model of a four-state extended burst-mode controller. It watches three input lines (`in_a`, `in_b`, `in_c`) and waits until every edge of the burst expected in its current state has arrived. Those edges may come in any order and over several clock cycles. When the burst is complete, and its level guard on `in_b` holds, the block moves to the next state and drives the matching output burst on `out_x` and `out_y` in the same clock edge.

Some inputs are directed don't-cares in some states: they may toggle freely without causing a transition or blocking one. Any other unexpected behaviour raises a sticky error flag, which freezes the controller until reset. This includes an input that belongs to no burst, an edge that reverses before its burst completes, two competing bursts that both start, and an input change inside the settle window that follows an output burst.

Bit positions used in masks are a = bit 0, b = bit 1, c = bit 2. State codes on `state_o` are 0 = REST, 1 = LIVE, 2 = CWAIT, 3 = XOUT.

Top module: `ebm_ctl`

## Requirements
- R1: After reset, `state_o` is 0 (REST), `out_x` = 0, `out_y` = 0 and `err_o` = 0, with all inputs expected low.
- R2: In REST, once both a rising edge on `in_a` and a rising edge on `in_b` have been seen (either order, same or different cycles), the block enters LIVE (1) with `out_y` = 1 and `out_x` = 0 at the edge that samples the last of the two.
- R3: In LIVE, a rising `in_c` moves to CWAIT (2) with `out_y` = 0 only while `in_b` is low. If `in_b` is high, the block waits in LIVE with no error and fires when `in_b` falls.
- R4: In CWAIT, a falling `in_c` returns to LIVE (1) with `out_y` = 1.
- R5: In LIVE, a falling `in_a` moves to XOUT (3) with `out_x` = 1 and `out_y` = 0 only while `in_b` is high. If `in_b` is low, the block waits with no error and fires when `in_b` rises.
- R6: In XOUT, a falling `in_b` returns to REST (0) with `out_x` = 0 and `out_y` = 0.
- R7: `in_b` is a don't-care in LIVE and CWAIT. Toggling it there (outside the settle window) changes neither state nor outputs and raises no error.
- R8: An input change that is neither part of a burst of the current state nor a don't-care sets `err_o`. If a burst completes in that same cycle, no transition is taken.
- R9: An input that returns to its starting level after its edge was counted, before the burst completes, sets `err_o`.
- R10: Any input change sampled within SETTLE_CYC clock edges after a transition sets `err_o`. A change first sampled at edge SETTLE_CYC+1 after the transition is accepted.
- R11: `err_o` stays set until reset, and while it is set `state_o`, `out_x` and `out_y` do not change.
- R12: In LIVE, if edges of both competing bursts (`in_a` falling and `in_c` rising) have been seen, `err_o` is set and no transition is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Burst input a |
| in_b | input | 1 | Burst input b, also the level guard |
| in_c | input | 1 | Burst input c |
| out_x | output | 1 | Output line x |
| out_y | output | 1 | Output line y |
| state_o | output | 2 | Current state code (0 REST, 1 LIVE, 2 CWAIT, 3 XOUT) |
| err_o | output | 1 | Sticky protocol-violation flag |

## Verification
Two functions can fall in the same cycle: completion of a burst and detection of a violation. The bench provokes this by raising `in_b`, which completes the REST burst, in the very cycle that the illegal `in_c` rises. It then checks that `err_o` is set and that `state_o` stays REST with both outputs low. The settle window is also probed at both of its edges. A change one edge too early must flag, and a change exactly one edge after the window must be accepted.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  localparam int NUM_IN  = 3;
  localparam int NUM_ALT = 2;
  localparam int IN_A = 0;
  localparam int IN_B = 1;
  localparam int IN_C = 2;

  typedef enum logic [1:0] {
    ST_REST  = 2'd0,
    ST_LIVE  = 2'd1,
    ST_CWAIT = 2'd2,
    ST_XOUT  = 2'd3
  } ctl_state_e;

  typedef logic [NUM_IN-1:0] in_vec_t;

  // Edges that make up burst alternative 'alt' of state 'st'.
  function automatic in_vec_t burst_mask(ctl_state_e st, int alt);
    in_vec_t m;
    m = '0;
    case (st)
      ST_REST:  if (alt == 0) m = in_vec_t'(3'b011);
      ST_LIVE:  if (alt == 0) m = in_vec_t'(3'b100);
                else          m = in_vec_t'(3'b001);
      ST_CWAIT: if (alt == 0) m = in_vec_t'(3'b100);
      ST_XOUT:  if (alt == 0) m = in_vec_t'(3'b010);
      default:  m = '0;
    endcase
    return m;
  endfunction

  // Inputs allowed to wander in a state.
  function automatic in_vec_t dc_mask(ctl_state_e st);
    in_vec_t m;
    case (st)
      ST_LIVE, ST_CWAIT: m = in_vec_t'(3'b010);
      default:           m = '0;
    endcase
    return m;
  endfunction

  function automatic in_vec_t care_mask(ctl_state_e st);
    in_vec_t m;
    m = '0;
    for (int k = 0; k < NUM_ALT; k++) m = m | burst_mask(st, k);
    return m;
  endfunction

  // Level guard on b, checked when the burst completes.
  function automatic logic guard_ok(ctl_state_e st, int alt, in_vec_t lvl);
    logic ok;
    ok = 1'b1;
    if (st == ST_LIVE) begin
      if (alt == 0) ok = (lvl[IN_B] == 1'b0);
      else          ok = (lvl[IN_B] == 1'b1);
    end
    return ok;
  endfunction

  function automatic ctl_state_e dest(ctl_state_e st, int alt);
    ctl_state_e d;
    case (st)
      ST_REST:  d = ST_LIVE;
      ST_LIVE:  d = (alt == 0) ? ST_CWAIT : ST_XOUT;
      ST_CWAIT: d = ST_LIVE;
      ST_XOUT:  d = ST_REST;
      default:  d = ST_REST;
    endcase
    return d;
  endfunction

  // {x, y} driven while resident in a state.
  function automatic logic [1:0] out_of(ctl_state_e st);
    logic [1:0] o;
    case (st)
      ST_LIVE: o = 2'b01;
      ST_XOUT: o = 2'b10;
      default: o = 2'b00;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/ebm_edge_track.sv
module ebm_edge_track
  import ebm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  in_vec_t diff,
  input  in_vec_t care,
  input  in_vec_t dcm,
  input  logic    clear,
  output in_vec_t seen_q,
  output in_vec_t seen_nx,
  output logic    illegal,
  output logic    reversal
);

  assign seen_nx  = seen_q | (diff & care);
  assign illegal  = |(diff & ~care & ~dcm);
  assign reversal = |(seen_q & ~diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= '0;
    else if (clear) seen_q <= '0;
    else            seen_q <= seen_nx;
  end

  // R2
  seen_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (seen_q == '0));

endmodule

// File: rtl/ebm_settle_timer.sv
module ebm_settle_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic chg,
  output logic busy,
  output logic violation
);

  localparam int CW = $clog2(SETTLE_CYC + 1) + 1;
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  assign busy      = (cnt_q != '0);
  assign violation = busy & chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= LOAD;
    else if (busy)  cnt_q <= cnt_q - 1'b1;
  end

  // R10
  window_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R10
  window_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/ebm_burst_match.sv
module ebm_burst_match
  import ebm_pkg::*;
#(
  parameter int ALT = 0
) (
  input  ctl_state_e st,
  input  in_vec_t    seen_nx,
  input  in_vec_t    lvl,
  output logic       touched,
  output logic       take
);

  in_vec_t mask;
  logic    complete;

  assign mask     = burst_mask(st, ALT);
  assign touched  = |(seen_nx & mask);
  assign complete = (mask != '0) && ((seen_nx & mask) == mask);
  assign take     = complete && guard_ok(st, ALT, lvl);

endmodule

// File: rtl/ebm_ctl.sv
module ebm_ctl
  import ebm_pkg::*;
#(
  parameter int SETTLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_a,
  input  logic       in_b,
  input  logic       in_c,
  output logic       out_x,
  output logic       out_y,
  output logic [1:0] state_o,
  output logic       err_o
);

  ctl_state_e state_q, state_nx;
  in_vec_t    lvl, lvl_q, ref_q, diff, care, dcm;
  in_vec_t    seen_q, seen_nx;
  logic       illegal, reversal, conflict, settle_viol, err_now, err_q;
  logic       chg, fire, sel, settle_busy;
  logic [NUM_ALT-1:0] touched, take;
  logic [1:0] xy_q;

  assign lvl  = {in_c, in_b, in_a};
  assign chg  = (lvl != lvl_q);
  assign diff = lvl ^ ref_q;
  assign care = care_mask(state_q);
  assign dcm  = dc_mask(state_q);

  ebm_edge_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .diff     (diff),
    .care     (care),
    .dcm      (dcm),
    .clear    (fire),
    .seen_q   (seen_q),
    .seen_nx  (seen_nx),
    .illegal  (illegal),
    .reversal (reversal)
  );

  ebm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fire),
    .chg       (chg),
    .busy      (settle_busy),
    .violation (settle_viol)
  );

  for (genvar g = 0; g < NUM_ALT; g++) begin : g_alt
    ebm_burst_match #(.ALT(g)) u_match (
      .st      (state_q),
      .seen_nx (seen_nx),
      .lvl     (lvl),
      .touched (touched[g]),
      .take    (take[g])
    );
  end

  assign conflict = &touched;
  assign err_now  = illegal | reversal | conflict | settle_viol;
  assign fire     = (|take) & ~err_now & ~err_q;
  assign sel      = ~take[0];
  assign state_nx = dest(state_q, sel ? 1 : 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REST;
      xy_q    <= 2'b00;
      ref_q   <= '0;
      lvl_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (err_now) err_q <= 1'b1;
      if (fire) begin
        state_q <= state_nx;
        xy_q    <= out_of(state_nx);
        ref_q   <= lvl;
      end
    end
  end

  assign out_x   = xy_q[1];
  assign out_y   = xy_q[0];
  assign state_o = state_q;
  assign err_o   = err_q;

  // R11
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && $stable(state_o) && $stable(out_x) && $stable(out_y)));

  // R8
  err_on_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> err_o);

  // R8
  no_move_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> $stable(state_o));

  // R2
  fire_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (state_o != $past(state_o)));

  // R5
  x_only_xout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_x |-> (state_o == 2'd3 && !out_y));

  // R12
  conflict_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> err_o);

endmodule

// File: tb/ebm_ctl_bench.sv
module ebm_ctl_bench;

  localparam int SETTLE = 3;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, c = 1'b0;
  logic x, y, err;
  logic [1:0] st;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ebm_ctl #(.SETTLE_CYC(SETTLE)) u_ebm_ctl (
    .clk(clk), .rst_n(rst_n), .in_a(a), .in_b(b), .in_c(c),
    .out_x(x), .out_y(y), .state_o(st), .err_o(err)
  );

  // {a,b,c} applied, then expected {state, x, y, err}
  localparam logic [7:0] VEC [NV] = '{
    {3'b100, 2'd0, 1'b0, 1'b0, 1'b0},  // R2 half burst
    {3'b110, 2'd1, 1'b0, 1'b1, 1'b0},  // R2 complete
    {3'b100, 2'd1, 1'b0, 1'b1, 1'b0},  // R7 b toggles in LIVE
    {3'b110, 2'd1, 1'b0, 1'b1, 1'b0},  // R7
    {3'b111, 2'd1, 1'b0, 1'b1, 1'b0},  // R3 guard blocks
    {3'b101, 2'd2, 1'b0, 1'b0, 1'b0},  // R3 fires on b low
    {3'b111, 2'd2, 1'b0, 1'b0, 1'b0},  // R7 b in CWAIT
    {3'b110, 2'd1, 1'b0, 1'b1, 1'b0},  // R4
    {3'b100, 2'd1, 1'b0, 1'b1, 1'b0},  // R7
    {3'b000, 2'd1, 1'b0, 1'b1, 1'b0},  // R5 guard blocks
    {3'b010, 2'd3, 1'b1, 1'b0, 1'b0},  // R5 fires on b high
    {3'b000, 2'd0, 1'b0, 1'b0, 1'b0},  // R6
    {3'b010, 2'd0, 1'b0, 1'b0, 1'b0},  // R2 b first
    {3'b110, 2'd1, 1'b0, 1'b1, 1'b0}   // R2 other order
  };

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {st, x, y, err};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {state,x,y,err} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; a = 0; b = 0; c = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic apply(logic [2:0] abc);
    @(negedge clk) {a, b, c} = abc;
    repeat (SETTLE + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1 reset", {2'd0, 1'b0, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][7:5]);
      check($sformatf("R2-R7 vector %0d", i), VEC[i][4:0]);
    end

    // R8 illegal c in REST, then R11 sticky and frozen
    do_reset();
    apply(3'b001);
    check("R8 illegal input", {2'd0, 1'b0, 1'b0, 1'b1});
    apply(3'b111);
    check("R11 frozen after error", {2'd0, 1'b0, 1'b0, 1'b1});

    // R8 same cycle: burst completes with illegal c
    do_reset();
    apply(3'b100);
    apply(3'b111);
    check("R8 completion with illegal change", {2'd0, 1'b0, 1'b0, 1'b1});

    // R9 reversal
    do_reset();
    apply(3'b100);
    apply(3'b000);
    check("R9 edge reversal", {2'd0, 1'b0, 1'b0, 1'b1});

    // R10 change one edge inside window
    do_reset();
    @(negedge clk) {a, b, c} = 3'b110;
    @(posedge clk);
    repeat (SETTLE - 1) @(posedge clk);
    @(negedge clk) b = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 change inside settle window", {2'd1, 1'b0, 1'b1, 1'b1});

    // R10 change first sampled just after window
    do_reset();
    @(negedge clk) {a, b, c} = 3'b110;
    @(posedge clk);
    repeat (SETTLE) @(posedge clk);
    @(negedge clk) b = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10 change after settle window", {2'd1, 1'b0, 1'b1, 1'b0});

    // R12 competing bursts in LIVE
    do_reset();
    apply(3'b110);
    apply(3'b111);
    apply(3'b011);
    check("R12 competing bursts", {2'd1, 1'b0, 1'b1, 1'b1});

    finish_run();
  end

endmodule